// File: doc/BRIEF.md
# Debounced Key-Line Encoder

This block turns a bank of active-high key lines into a compact binary key number. A designer places it behind a set of key switches that are wired with pull-ups. The key lines are captured into a register. They then pass through a stable-count filter, which removes contact bounce and skew between the lines. A priority encoder reduces the filtered pattern to the number of the highest active line.

Three outputs come out of the block. A strobe tells downstream logic when a valid number is present and can be latched. A separate flag shows that more than one key is held at once. When every key is released, the strobe drops and the code output keeps the last number it gave. Setting the filter length to zero removes the filter, and the outputs then follow the capture register directly.

Top module: `kenc_top`

## Requirements
- R1: Key line i (0 to NUM_KEYS-1) is encoded as the plain binary value i on `key_code`, which is 4 bits wide for 16 lines.
- R2: With STABLE_CYCLES = N > 0, a new key pattern that then stays unchanged reaches the outputs on the (N+2)th rising clock edge after it appears at the pins. A pattern held for N+1 cycles is accepted. With N = 0, the outputs follow on the first edge.
- R3: `key_strobe` is high exactly while the filtered pattern contains at least one active line.
- R4: While `key_strobe` is low, `key_code` keeps the number of the last accepted key.
- R5: When more than one filtered line is active, `key_code` gives the highest-numbered line and `key_multi` is high. With a single key, `key_multi` is low.
- R6: With N > 0, a pattern held at the pins for N cycles or fewer is rejected. The outputs do not change. After the pattern returns, the previous result is still shown.
- R7: During reset and right after it, `key_code` is 0 and `key_strobe` and `key_multi` are low.
- R8: A release of all keys also passes through the filter. `key_strobe` and `key_multi` fall with the same latency as in R2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| keys_in | input | NUM_KEYS | Raw key lines, active high |
| key_code | output | CODE_W | Binary number of the winning key (held while no key) |
| key_strobe | output | 1 | High while a filtered key is present |
| key_multi | output | 1 | High while more than one filtered key is present |

## Verification
The bench builds two copies that are driven by the same key lines. One copy uses a filter length of 4. Its acceptance edge is short enough to probe exactly: pulses of 1, 2 and 4 cycles must be rejected, and a hold of exactly 5 cycles must be accepted. The other copy uses a filter length of 0. It selects the bypass variant, so the single-edge path and the same encoding can be compared under identical stimulus.

// File: rtl/kenc_pkg.sv
package kenc_pkg;

   // bits needed to index n items, never fewer than one
   function automatic int code_bits(input int n);
      return (n <= 2) ? 1 : $clog2(n);
   endfunction

endpackage

// File: rtl/kenc_prio.sv
module kenc_prio
   import kenc_pkg::*;
#(
   parameter int NUM_KEYS = 16,
   parameter int CODE_W   = 4
) (
   input  logic [NUM_KEYS-1:0] lines,
   output logic [CODE_W-1:0]   idx,
   output logic                any,
   output logic                multi
);

   logic [NUM_KEYS-1:0] seen;
   logic [NUM_KEYS-1:0] dup;

   // ripple chain: seen = some line at or below g, dup = a second one found
   generate
      for (genvar g = 0; g < NUM_KEYS; g++) begin : g_chain
         if (g == 0) begin : g_first
            assign seen[g] = lines[g];
            assign dup[g]  = 1'b0;
         end else begin : g_next
            assign seen[g] = seen[g-1] | lines[g];
            assign dup[g]  = dup[g-1] | (seen[g-1] & lines[g]);
         end
      end
   endgenerate

   assign any   = seen[NUM_KEYS-1];
   assign multi = dup[NUM_KEYS-1];

   // later (higher) lines overwrite earlier ones
   always_comb begin
      idx = '0;
      for (int i = 0; i < NUM_KEYS; i++) begin
         if (lines[i]) idx = CODE_W'(i);
      end
   end

endmodule

// File: rtl/kenc_filter.sv
module kenc_filter
   import kenc_pkg::*;
#(
   parameter int NUM_KEYS      = 16,
   parameter int STABLE_CYCLES = 8
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [NUM_KEYS-1:0] keys_in,
   output logic [NUM_KEYS-1:0] key_q,
   output logic [NUM_KEYS-1:0] accepted
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) key_q <= '0;
      else        key_q <= keys_in;
   end

   generate
      if (STABLE_CYCLES == 0) begin : g_bypass
         assign accepted = key_q;
      end else begin : g_count
         localparam int CNT_W = code_bits(STABLE_CYCLES);
         localparam logic [CNT_W-1:0] LAST = CNT_W'(STABLE_CYCLES - 1);

         logic [NUM_KEYS-1:0] cand;
         logic [CNT_W-1:0]    cnt;
         logic [NUM_KEYS-1:0] acc_r;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               cand  <= '0;
               cnt   <= '0;
               acc_r <= '0;
            end else if (key_q != cand) begin
               cand <= key_q;
               cnt  <= '0;
            end else if (cnt == LAST) begin
               acc_r <= cand;
            end else begin
               cnt <= cnt + 1'b1;
            end
         end

         assign accepted = acc_r;
      end
   endgenerate

endmodule

// File: rtl/kenc_top.sv
module kenc_top
   import kenc_pkg::*;
#(
   parameter int  NUM_KEYS      = 16,
   parameter int  STABLE_CYCLES = 8,
   localparam int CODE_W        = code_bits(NUM_KEYS)
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [NUM_KEYS-1:0] keys_in,
   output logic [CODE_W-1:0]   key_code,
   output logic                key_strobe,
   output logic                key_multi
);

   generate
      if (NUM_KEYS < 2) begin : g_bad_keys
         $error("kenc_top: NUM_KEYS must be at least 2");
      end
      if (STABLE_CYCLES < 0) begin : g_bad_stable
         $error("kenc_top: STABLE_CYCLES must not be negative");
      end
   endgenerate

   logic [NUM_KEYS-1:0] key_q;
   logic [NUM_KEYS-1:0] accepted;
   logic [CODE_W-1:0]   win_idx;
   logic                win_any;
   logic                win_multi;
   logic [CODE_W-1:0]   code_hold;

   kenc_filter #(
      .NUM_KEYS      (NUM_KEYS),
      .STABLE_CYCLES (STABLE_CYCLES)
   ) u_filter (
      .clk      (clk),
      .rst_n    (rst_n),
      .keys_in  (keys_in),
      .key_q    (key_q),
      .accepted (accepted)
   );

   kenc_prio #(
      .NUM_KEYS (NUM_KEYS),
      .CODE_W   (CODE_W)
   ) u_prio (
      .lines (accepted),
      .idx   (win_idx),
      .any   (win_any),
      .multi (win_multi)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       code_hold <= '0;
      else if (win_any) code_hold <= win_idx;
   end

   assign key_code   = win_any ? win_idx : code_hold;
   assign key_strobe = win_any;
   assign key_multi  = win_multi;

endmodule

// File: rtl/kenc_chk.sv
module kenc_chk
   import kenc_pkg::*;
#(
   parameter int NUM_KEYS      = 16,
   parameter int STABLE_CYCLES = 8,
   parameter int CODE_W        = 4
) (
   input logic                clk,
   input logic                rst_n,
   input logic [NUM_KEYS-1:0] key_q,
   input logic [NUM_KEYS-1:0] accepted,
   input logic [CODE_W-1:0]   key_code,
   input logic                key_strobe,
   input logic                key_multi
);

   // R1
   code_line_active_chk: assert property (@(posedge clk) disable iff (!rst_n)
      key_strobe |-> accepted[key_code]);

   // R3
   idle_no_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (accepted == '0) |-> !key_strobe);

   // R4
   code_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !key_strobe |-> $stable(key_code));

   // R5
   multi_needs_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
      key_multi |-> key_strobe);

   // R5
   multi_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($countones(accepted) > 1) |-> key_multi);

   generate
      if (STABLE_CYCLES > 0) begin : g_run
         localparam int RUN_W = code_bits(STABLE_CYCLES + 2);
         logic [RUN_W-1:0]    run;
         logic [NUM_KEYS-1:0] prev_q;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               run    <= '0;
               prev_q <= '0;
            end else begin
               prev_q <= key_q;
               if (key_q != prev_q)                  run <= '0;
               else if (run != RUN_W'(STABLE_CYCLES)) run <= run + 1'b1;
            end
         end

         // R6
         steady_before_change_chk: assert property (@(posedge clk) disable iff (!rst_n)
            !$stable({key_code, key_strobe, key_multi}) |-> (run >= RUN_W'(STABLE_CYCLES)));
      end
   endgenerate

endmodule

bind kenc_top kenc_chk #(
   .NUM_KEYS      (NUM_KEYS),
   .STABLE_CYCLES (STABLE_CYCLES),
   .CODE_W        (CODE_W)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .key_q      (key_q),
   .accepted   (accepted),
   .key_code   (key_code),
   .key_strobe (key_strobe),
   .key_multi  (key_multi)
);

// File: tb/kenc_top_test.sv
module kenc_top_test;

   localparam int NK   = 16;
   localparam int N    = 4;
   localparam int CW   = 4;

   typedef struct {
      logic [CW+1:0] tup;
      int            due;
      string         tag;
   } item_t;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [NK-1:0] keys = '0;
   logic [CW-1:0] f_code, r_code;
   logic          f_strobe, f_multi, r_strobe, r_multi;

   int cyc = 0;
   int compared = 0;
   int mismatched = 0;
   bit running = 1'b0;

   item_t qf[$];
   item_t qr[$];
   logic [CW+1:0] mf = '0, mr = '0;     // model state
   logic [CW+1:0] lf = '0, lr = '0;     // last observed

   always #5 clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   kenc_top #(.NUM_KEYS(NK), .STABLE_CYCLES(N)) uut (
      .clk(clk), .rst_n(rst_n), .keys_in(keys),
      .key_code(f_code), .key_strobe(f_strobe), .key_multi(f_multi));

   kenc_top #(.NUM_KEYS(NK), .STABLE_CYCLES(0)) uut_raw (
      .clk(clk), .rst_n(rst_n), .keys_in(keys),
      .key_code(r_code), .key_strobe(r_strobe), .key_multi(r_multi));

   function automatic logic [CW+1:0] expect_tup(input logic [NK-1:0] p,
                                                input logic [CW-1:0] last_code);
      logic [CW-1:0] c;
      c = last_code;
      for (int i = 0; i < NK; i++) if (p[i]) c = CW'(i);
      return {c, (p != '0), ($countones(p) > 1)};
   endfunction

   task automatic check(input bit ok, input string tag, input logic [CW+1:0] act,
                        input logic [CW+1:0] exp);
      compared++;
      if (!ok) begin
         mismatched++;
         $display("FAIL %s: actual code/strobe/multi=%h expected=%h", tag, act, exp);
      end
   endtask

   // driver: apply a pattern for 'hold' cycles and queue what must follow
   task automatic step(input logic [NK-1:0] p, input int hold, input string tag);
      logic [CW+1:0] t;
      item_t it;
      @(negedge clk);
      keys = p;
      t = expect_tup(p, mr[CW+1:2]);
      if (t != mr) begin
         it.tup = t; it.due = cyc + 1; it.tag = tag;
         qr.push_back(it);
      end
      mr = t;
      if (hold >= N + 1) begin
         t = expect_tup(p, mf[CW+1:2]);
         if (t != mf) begin
            it.tup = t; it.due = cyc + N + 2; it.tag = tag;
            qf.push_back(it);
         end
         mf = t;
      end
      repeat (hold - 1) @(negedge clk);
   endtask

   // monitor for the filtered copy
   always @(negedge clk) begin
      if (running) begin
         logic [CW+1:0] obs;
         obs = {f_code, f_strobe, f_multi};
         if (obs != lf) begin
            if (qf.size() == 0) begin
               check(1'b0, "R6 unexpected filtered change", obs, lf);
            end else begin
               item_t it;
               it = qf.pop_front();
               check(obs == it.tup && cyc == it.due,
                     $sformatf("%s filtered (cycle %0d, due %0d)", it.tag, cyc, it.due),
                     obs, it.tup);
            end
            lf = obs;
         end
         if (qf.size() > 0 && cyc > qf[0].due) begin
            item_t it;
            it = qf.pop_front();
            check(1'b0, {"R2 late filtered ", it.tag}, obs, it.tup);
         end
      end
   end

   // monitor for the bypass copy
   always @(negedge clk) begin
      if (running) begin
         logic [CW+1:0] obs;
         obs = {r_code, r_strobe, r_multi};
         if (obs != lr) begin
            if (qr.size() == 0) begin
               check(1'b0, "R2 unexpected bypass change", obs, lr);
            end else begin
               item_t it;
               it = qr.pop_front();
               check(obs == it.tup && cyc == it.due,
                     $sformatf("%s bypass (cycle %0d, due %0d)", it.tag, cyc, it.due),
                     obs, it.tup);
            end
            lr = obs;
         end
         if (qr.size() > 0 && cyc > qr[0].due) begin
            item_t it;
            it = qr.pop_front();
            check(1'b0, {"R2 late bypass ", it.tag}, obs, it.tup);
         end
      end
   end

   task automatic finish_run();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      check(1'b0, "watchdog expired", '0, '0);
      finish_run();
   end

   initial begin
      keys = 16'h0003;
      repeat (3) @(negedge clk);
      // R7: outputs idle during reset
      check({f_code, f_strobe, f_multi} == '0, "R7 reset filtered", {f_code, f_strobe, f_multi}, '0);
      check({r_code, r_strobe, r_multi} == '0, "R7 reset bypass", {r_code, r_strobe, r_multi}, '0);
      keys = '0;
      @(negedge clk);
      rst_n = 1'b1;
      running = 1'b1;
      @(negedge clk);
      check({f_code, f_strobe, f_multi} == '0, "R7 after reset", {f_code, f_strobe, f_multi}, '0);

      step(16'h0001, 10, "R1");
      step(16'h0000, 10, "R8");
      step(16'h0020, 10, "R1");
      step(16'h0000, 10, "R4");
      // R4: code 5 kept with strobe low
      check({f_code, f_strobe, f_multi} == {4'd5, 2'b00}, "R4 held code",
            {f_code, f_strobe, f_multi}, {4'd5, 2'b00});
      step(16'h8000, 10, "R1");
      step(16'h8004, 10, "R5");
      step(16'h0006, 10, "R5");
      step(16'h0004, 10, "R3");
      // R6: bounce pulses of 2, 1 and N cycles
      step(16'h0100, 2, "R6");
      step(16'h0004, 1, "R6");
      step(16'h0100, N, "R6");
      step(16'h0004, 10, "R6");
      check({f_code, f_strobe, f_multi} == {4'd2, 2'b10}, "R6 result kept",
            {f_code, f_strobe, f_multi}, {4'd2, 2'b10});
      step(16'h0000, 10, "R8");
      // R2: hold of exactly N+1 cycles is accepted
      step(16'h0400, N + 1, "R2");
      step(16'h0000, 10, "R8");
      step(16'hFFFF, 10, "R5");
      step(16'h0000, 10, "R4");
      repeat (10) @(negedge clk);
      check(qf.size() == 0, "R2 filtered queue drained", CW'(qf.size()), '0);
      check(qr.size() == 0, "R2 bypass queue drained", CW'(qr.size()), '0);
      finish_run();
   end

endmodule